// File: doc/BRIEF.md
# Prioritized Exception Arbiter

This block picks, among all exceptions currently pending, the one that should run next, and decides whether that exception may interrupt the handler now executing. There are three kinds of candidate. Three fixed sources (reset, non-maskable interrupt and hard fault) rank above everything else. Seven system handlers each carry a 3-bit programmable priority. A parameterised set of interrupt lines each carries an enable bit and a 3-bit priority.

A 2-bit grouping field splits every programmable priority into an upper preemption field and a lower subpriority field. The full priority picks the winner. Only the preemption field decides whether the winner may break into the active handler. When the active handler signals its return and an eligible exception is waiting, the block flags a tail-chain instead of a preemption, so the surrounding core can skip the state restore and re-save. All results are registered.

Ranks are shared between inputs and outputs. Reset is rank 0, NMI is rank 1 and hard fault is rank 2. A programmable priority p has rank 3+p. Exception numbers: 1 is reset, 2 is NMI, 3 is hard fault, 4+k is system handler k, 16+i is interrupt line i, and 0 means none.

Top module: `exc_arbiter`

## Requirements
- R1: While reset is asserted, and at the first sample after it, excValid, excNum, excRank, preemptReq and tailChain are all 0.
- R2: A pending reset gives excNum 1. Otherwise a pending NMI gives 2. Otherwise a pending hard fault gives 3. Each of these wins over every programmable source.
- R3: Interrupt line i is a candidate only while both irqPend[i] and irqEn[i] are 1.
- R4: Among programmable candidates, the smallest 3-bit priority value wins (0 is most urgent). On equal values the lowest exception number wins. excRank reports 3 plus the winning priority.
- R5: With grouping value g, the preemption level of a programmable rank is its priority with the low g bits cleared. Fixed ranks keep their own value as their level.
- R6: With handlerReturn low, preemptReq is 1 when a winner exists and either activeValid is 0 or the winner's preemption level is strictly below that of activeRank.
- R7: With handlerReturn high, the same eligibility raises tailChain instead, and preemptReq stays 0.
- R8: Every output reflects the inputs present at the previous rising clock edge: one register stage.
- R9: With no candidate, excValid is 0, excNum and excRank are 0, and neither request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rstPend | input | 1 | Reset exception pending |
| nmiPend | input | 1 | Non-maskable interrupt pending |
| hfPend | input | 1 | Hard fault pending |
| sysPend | input | 7 | System handler pending bits |
| sysPrio | input | 21 | System handler priorities, 3 bits each, handler k at [3k+2:3k] |
| irqPend | input | NUM_IRQ | Interrupt pending lines |
| irqEn | input | NUM_IRQ | Interrupt enable bits |
| irqPrio | input | 3*NUM_IRQ | Interrupt priorities, line i at [3i+2:3i] |
| grouping | input | 2 | Number of subpriority bits (0 to 3) |
| activeValid | input | 1 | A handler is currently active |
| activeRank | input | 4 | Rank of the active handler |
| handlerReturn | input | 1 | Active handler is returning this cycle |
| excValid | output | 1 | A winner exists |
| excNum | output | 8 | Winning exception number |
| excRank | output | 4 | Rank of the winner |
| preemptReq | output | 1 | Winner may preempt the active handler |
| tailChain | output | 1 | Winner is taken directly after the returning handler |

## Verification
A wrong winner scan shows up one cycle later as a wrong excNum or excRank. Such an error is most telling on priority ties and on disabled lines that hold urgent priorities. A wrong subpriority mask leaves excNum correct but flips preemptReq whenever the winner and the active handler differ only in their low bits. The bench therefore sweeps every grouping value against nearby active ranks. A mix-up of the return path shows the same cycle as preemptReq and tailChain swapping roles.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int PRIO_W   = 3;
  localparam int FIXED_N  = 3;
  localparam int SYS_N    = 7;
  localparam int SYS_BASE = 4;
  localparam int IRQ_BASE = 16;
  localparam int RANK_W   = $clog2(FIXED_N + (1 << PRIO_W));

  // strobes from control to datapath
  typedef struct packed {
    logic [PRIO_W-1:0] subMask;
    logic              ignoreActive;
  } ctrl_t;

  // preemption level: fixed ranks unchanged, programmable ranks lose subpriority bits
  function automatic logic [RANK_W-1:0] preemptLevel(input logic [RANK_W-1:0] rank,
                                                     input logic [PRIO_W-1:0] subMask);
    logic [RANK_W-1:0] off;
    if (rank < RANK_W'(FIXED_N)) return rank;
    off = rank - RANK_W'(FIXED_N);
    return RANK_W'(FIXED_N) + (off & ~RANK_W'(subMask));
  endfunction
endpackage

// File: rtl/exc_arb_ctrl.sv
module exc_arb_ctrl
  import exc_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] grouping,
  input  logic       activeValid,
  input  logic       handlerReturn,
  input  logic       eligible,
  output ctrl_t      ctrl,
  output logic       preemptReq,
  output logic       tailChain
);
  always_comb begin
    ctrl.subMask      = PRIO_W'((1 << grouping) - 1);
    ctrl.ignoreActive = !activeValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preemptReq <= 1'b0;
      tailChain  <= 1'b0;
    end else begin
      preemptReq <= eligible && !handlerReturn;
      tailChain  <= eligible && handlerReturn;
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({preemptReq, tailChain}));
  a_r7_tail_after_return: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tailChain) |-> $past(handlerReturn));
  a_r6_preempt_no_return: assert property (@(posedge clk) disable iff (!rstN)
    $rose(preemptReq) |-> !$past(handlerReturn));
endmodule

// File: rtl/exc_arb_dp.sv
module exc_arb_dp
  import exc_arb_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_t                     ctrl,
  input  logic                      rstPend,
  input  logic                      nmiPend,
  input  logic                      hfPend,
  input  logic [SYS_N-1:0]          sysPend,
  input  logic [SYS_N*PRIO_W-1:0]   sysPrio,
  input  logic [NUM_IRQ-1:0]        irqPend,
  input  logic [NUM_IRQ-1:0]        irqEn,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [RANK_W-1:0]         activeRank,
  output logic                      eligible,
  output logic                      excValid,
  output logic [NUM_W-1:0]          excNum,
  output logic [RANK_W-1:0]         excRank
);
  localparam int CAND_N = FIXED_N + SYS_N + NUM_IRQ;

  logic              candValid [CAND_N];
  logic [RANK_W-1:0] candRank  [CAND_N];
  logic [NUM_W-1:0]  candNum   [CAND_N];

  assign candValid[0] = rstPend;
  assign candValid[1] = nmiPend;
  assign candValid[2] = hfPend;

  for (genvar f = 0; f < FIXED_N; f++) begin : g_fixed
    assign candRank[f] = RANK_W'(f);
    assign candNum[f]  = NUM_W'(f + 1);
  end

  for (genvar k = 0; k < SYS_N; k++) begin : g_sys
    assign candValid[FIXED_N+k] = sysPend[k];
    assign candRank[FIXED_N+k]  = RANK_W'(FIXED_N) + RANK_W'(sysPrio[k*PRIO_W +: PRIO_W]);
    assign candNum[FIXED_N+k]   = NUM_W'(SYS_BASE + k);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign candValid[FIXED_N+SYS_N+i] = irqPend[i] & irqEn[i];
    assign candRank[FIXED_N+SYS_N+i]  = RANK_W'(FIXED_N) + RANK_W'(irqPrio[i*PRIO_W +: PRIO_W]);
    assign candNum[FIXED_N+SYS_N+i]   = NUM_W'(IRQ_BASE + i);
  end

  logic              found;
  logic [RANK_W-1:0] bestRank;
  logic [NUM_W-1:0]  bestNum;

  // candidates are ordered by exception number; strict compare keeps the lowest number on ties
  always_comb begin
    found    = 1'b0;
    bestRank = '0;
    bestNum  = '0;
    for (int c = 0; c < CAND_N; c++) begin
      if (candValid[c] && (!found || candRank[c] < bestRank)) begin
        found    = 1'b1;
        bestRank = candRank[c];
        bestNum  = candNum[c];
      end
    end
    eligible = found && (ctrl.ignoreActive ||
               preemptLevel(bestRank, ctrl.subMask) < preemptLevel(activeRank, ctrl.subMask));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excValid <= 1'b0;
      excNum   <= '0;
      excRank  <= '0;
    end else begin
      excValid <= found;
      excNum   <= bestNum;
      excRank  <= bestRank;
    end
  end

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !excValid |-> (excNum == '0 && excRank == '0));
  a_r8_one_stage: assert property (@(posedge clk) disable iff (!rstN)
    $rose(excValid) |-> $past(rstPend || nmiPend || hfPend || (|sysPend) || (|(irqPend & irqEn))));
  a_r2_reset_first: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstPend) && $past(rstN) |-> excNum == NUM_W'(1));
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rstPend,
  input  logic                      nmiPend,
  input  logic                      hfPend,
  input  logic [SYS_N-1:0]          sysPend,
  input  logic [SYS_N*PRIO_W-1:0]   sysPrio,
  input  logic [NUM_IRQ-1:0]        irqPend,
  input  logic [NUM_IRQ-1:0]        irqEn,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [1:0]                grouping,
  input  logic                      activeValid,
  input  logic [RANK_W-1:0]         activeRank,
  input  logic                      handlerReturn,
  output logic                      excValid,
  output logic [7:0]                excNum,
  output logic [RANK_W-1:0]         excRank,
  output logic                      preemptReq,
  output logic                      tailChain
);
  ctrl_t ctrl;
  logic  eligible;

  exc_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .grouping(grouping), .activeValid(activeValid),
    .handlerReturn(handlerReturn), .eligible(eligible), .ctrl(ctrl),
    .preemptReq(preemptReq), .tailChain(tailChain)
  );

  exc_arb_dp #(.NUM_IRQ(NUM_IRQ), .NUM_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rstPend(rstPend), .nmiPend(nmiPend),
    .hfPend(hfPend), .sysPend(sysPend), .sysPrio(sysPrio), .irqPend(irqPend),
    .irqEn(irqEn), .irqPrio(irqPrio), .activeRank(activeRank), .eligible(eligible),
    .excValid(excValid), .excNum(excNum), .excRank(excRank)
  );

  a_r6_request_has_winner: assert property (@(posedge clk) disable iff (!rstN)
    (preemptReq || tailChain) |-> excValid);
endmodule

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
  localparam int NI = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rstPend = 0, nmiPend = 0, hfPend = 0;
  logic [6:0] sysPend = '0;
  logic [20:0] sysPrio = '0;
  logic [NI-1:0] irqPend = '0, irqEn = '0;
  logic [NI*3-1:0] irqPrio = '0;
  logic [1:0] grouping = '0;
  logic activeValid = 0;
  logic [3:0] activeRank = '0;
  logic handlerReturn = 0;
  logic excValid;
  logic [7:0] excNum;
  logic [3:0] excRank;
  logic preemptReq, tailChain;

  int checks = 0, errors = 0;
  int eNum, eRank;
  bit eValid, ePre, eTail;

  always #2 clk = ~clk;

  exc_arbiter #(.NUM_IRQ(NI)) u0 (
    .clk(clk), .rstN(rstN), .rstPend(rstPend), .nmiPend(nmiPend), .hfPend(hfPend),
    .sysPend(sysPend), .sysPrio(sysPrio), .irqPend(irqPend), .irqEn(irqEn),
    .irqPrio(irqPrio), .grouping(grouping), .activeValid(activeValid),
    .activeRank(activeRank), .handlerReturn(handlerReturn), .excValid(excValid),
    .excNum(excNum), .excRank(excRank), .preemptReq(preemptReq), .tailChain(tailChain)
  );

  function automatic int lvl(int r, int g);
    if (r < 3) return r;
    return 3 + ((r - 3) >> g << g);
  endfunction

  task automatic model();
    eValid = 0; eNum = 0; eRank = 0;
    if (rstPend) begin eValid = 1; eNum = 1; eRank = 0; end
    else if (nmiPend) begin eValid = 1; eNum = 2; eRank = 1; end
    else if (hfPend) begin eValid = 1; eNum = 3; eRank = 2; end
    else begin
      for (int k = 0; k < 7; k++)
        if (sysPend[k] && (!eValid || 3 + int'(sysPrio[k*3 +: 3]) < eRank)) begin
          eValid = 1; eNum = 4 + k; eRank = 3 + int'(sysPrio[k*3 +: 3]);
        end
      for (int i = 0; i < NI; i++)
        if (irqPend[i] && irqEn[i] && (!eValid || 3 + int'(irqPrio[i*3 +: 3]) < eRank)) begin
          eValid = 1; eNum = 16 + i; eRank = 3 + int'(irqPrio[i*3 +: 3]);
        end
    end
    ePre = 0; eTail = 0;
    if (eValid && (!activeValid || lvl(eRank, grouping) < lvl(int'(activeRank), grouping))) begin
      if (handlerReturn) eTail = 1; else ePre = 1;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, outputs registered at next posedge, sample at the following negedge
  task automatic step(string req);
    model();
    @(posedge clk);
    @(negedge clk);
    chk({req, " excNum"}, excNum, eNum);
    chk({req, " excValid"}, excValid, eValid);
    chk({req, " excRank"}, excRank, eRank);
    chk({req, " preemptReq (R6)"}, preemptReq, ePre);
    chk({req, " tailChain (R7)"}, tailChain, eTail);
  endtask

  task automatic clearAll();
    rstPend = 0; nmiPend = 0; hfPend = 0; sysPend = '0; sysPrio = '0;
    irqPend = '0; irqEn = '0; irqPrio = '0; grouping = 0;
    activeValid = 0; activeRank = 0; handlerReturn = 0;
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    irqPend = '1; irqEn = '1; nmiPend = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset excValid", excValid, 0);
    chk("R1 reset excNum", excNum, 0);
    chk("R1 reset preemptReq", preemptReq, 0);
    clearAll();
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset excNum", excNum, 0);
    chk("R1 after reset tailChain", tailChain, 0);

    step("R9 idle");
    chk("R9 idle literal", excNum, 0);

    rstPend = 1; nmiPend = 1; hfPend = 1; irqPend[0] = 1; irqEn[0] = 1;
    step("R2 all fixed");
    chk("R2 reset wins literal", excNum, 1);
    rstPend = 0;
    step("R2 nmi over hf");
    chk("R2 nmi literal", excNum, 2);
    nmiPend = 0;
    step("R2 hf over irq");
    chk("R2 hf literal", excNum, 3);
    clearAll();

    irqPend = 16'h0003; irqEn = 16'h0002; irqPrio[2:0] = 0; irqPrio[5:3] = 6;
    step("R3 disabled line skipped");
    chk("R3 literal", excNum, 17);
    clearAll();

    irqPend = 16'h0006; irqEn = '1; irqPrio[5:3] = 4; irqPrio[8:6] = 4;
    sysPend[5] = 1; sysPrio[17:15] = 5;
    step("R4 tie lowest number");
    chk("R4 tie literal", excNum, 17);
    sysPrio[17:15] = 4;
    step("R4 sys beats irq on tie");
    chk("R4 sys literal", excNum, 9);
    chk("R4 rank literal", excRank, 7);
    clearAll();

    irqPend[0] = 1; irqEn[0] = 1; irqPrio[2:0] = 3;
    activeValid = 1; activeRank = 3 + 4;
    for (int g = 0; g < 4; g++) begin
      grouping = 2'(g);
      step("R5 grouping sweep");
    end
    grouping = 2; irqPrio[2:0] = 5;
    step("R5 equal preemption level blocks");
    chk("R5 literal no preempt", preemptReq, 0);
    grouping = 0; irqPrio[2:0] = 3; handlerReturn = 1;
    step("R7 tail chain");
    chk("R7 literal tail", tailChain, 1);
    handlerReturn = 0; activeRank = 2;
    step("R6 fixed active blocks");
    chk("R6 literal", preemptReq, 0);
    clearAll();

    for (int n = 0; n < 400; n++) begin
      rstPend = ($urandom % 16) == 0;
      nmiPend = ($urandom % 12) == 0;
      hfPend = ($urandom % 10) == 0;
      sysPend = 7'($urandom) & 7'($urandom);
      sysPrio = 21'($urandom);
      irqPend = 16'($urandom) & 16'($urandom);
      irqEn = 16'($urandom);
      irqPrio = {16'($urandom), 32'($urandom)};
      grouping = 2'($urandom);
      activeValid = 1'($urandom);
      activeRank = 4'($urandom % 11);
      handlerReturn = ($urandom % 4) == 0;
      step("R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule